// File: doc/BRIEF.md
# Data-Space Region Decoder with External Stall Control

This block sits between a small 8-bit processor core and its data memories. It sorts every 16-bit data address into one of six regions: working registers, standard I/O, extended I/O, on-chip SRAM, the off-chip memory window, or unmapped. A compatibility input moves the boundaries. When it is high, the extended I/O window is removed, on-chip SRAM starts right after standard I/O and holds 4000 bytes, and the off-chip window begins at 0x1000.

Accesses to on-chip regions finish without a stall, and the off-chip strobes stay quiet for them. An off-chip access drives exactly one strobe, read or write. It holds the ready output low for one cycle more than the programmed wait-state count. The core must keep its request steady until ready rises. When off-chip memory is disabled, addresses above on-chip SRAM are unmapped: reads from them return zero and writes to them do nothing.

Top module: `dspace_decoder`

## Requirements
- R1: With compat_i low, region_o encodes 0x0000-0x001F as 0 (registers), 0x0020-0x005F as 1 (standard I/O), 0x0060-0x00FF as 2 (extended I/O) and 0x0100-0x10FF as 3 (on-chip SRAM). Addresses from 0x1100 up give 4 (off-chip).
- R2: With compat_i high, region_o never reports 2. It encodes 0x0060-0x0FFF as 3 and addresses from 0x1000 up as 4. Regions 0 and 1 are unchanged.
- R3: A read or write that decodes to regions 0-3 or 5 keeps ext_rd_o and ext_wr_o low and has ready_o high in the same cycle.
- R4: With ext_en_i low, addresses above on-chip SRAM decode as 5 (unmapped). A read there returns rdata_o = 0x00, and neither strobe is raised for a read or a write.
- R5: An off-chip access with wait setting w (0-3) holds ready_o low for w+1 cycles. ready_o is then high for one cycle, so the access lasts w+2 cycles.
- R6: During every cycle of an off-chip access, exactly one strobe is high: ext_rd_o for a read, ext_wr_o for a write. Both strobes return low once the access completes.
- R7: wait_sel_i is captured in the first cycle of an off-chip access. Changes to it later in the same access do not alter the access length.
- R8: For mapped regions, rdata_o equals rdata_i.
- R9: During and right after reset, with no request pending, ready_o is high and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Data address from the core |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| compat_i | input | 1 | Compatibility layout (no extended I/O) |
| ext_en_i | input | 1 | Off-chip memory enable |
| wait_sel_i | input | 2 | Off-chip wait-state count, 0-3 |
| rdata_i | input | 8 | Read data from the selected memory |
| region_o | output | 3 | Decoded region code (see R1, R2, R4) |
| ext_rd_o | output | 1 | Off-chip read strobe |
| ext_wr_o | output | 1 | Off-chip write strobe |
| ready_o | output | 1 | Access completes this cycle; low means stall |
| rdata_o | output | 8 | Read data to the core, forced to zero when unmapped |

## Verification
The assertions assume the following about the core:
- rd_i and wr_i are never high together.
- An off-chip request, with its address and direction, is held unchanged until ready_o is seen high.

The bench stays within these assumptions. It raises only one request line at a time, keeps the address fixed through each off-chip access, and drops the request on the falling edge after the ready cycle. The only input it changes mid-access is wait_sel_i, which the block is required to ignore at that point.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    RGN_GPR  = 3'd0,
    RGN_SIO  = 3'd1,
    RGN_XIO  = 3'd2,
    RGN_SRAM = 3'd3,
    RGN_EXT  = 3'd4,
    RGN_NONE = 3'd5
  } region_e;
endpackage

// File: rtl/dsd_region_dec.sv
module dsd_region_dec
  import dsd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int GPR_CNT     = 32,
  parameter int SIO_CNT     = 64,
  parameter int XIO_CNT     = 160,
  parameter int SRAM_CNT    = 4096,
  parameter int SRAM_CNT_C  = 4000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              compat_i,
  input  logic              ext_en_i,
  output region_e           region_o
);
  localparam logic [ADDR_W-1:0] SIO_BASE  = ADDR_W'(GPR_CNT);
  localparam logic [ADDR_W-1:0] XIO_BASE  = ADDR_W'(GPR_CNT + SIO_CNT);
  localparam logic [ADDR_W-1:0] SRAM_N    = ADDR_W'(GPR_CNT + SIO_CNT + XIO_CNT);
  localparam logic [ADDR_W-1:0] EXT_N     = ADDR_W'(GPR_CNT + SIO_CNT + XIO_CNT + SRAM_CNT);
  localparam logic [ADDR_W-1:0] EXT_C     = ADDR_W'(GPR_CNT + SIO_CNT + SRAM_CNT_C);

  logic [ADDR_W-1:0] ext_base;
  assign ext_base = compat_i ? EXT_C : EXT_N;

  always_comb begin
    if (addr_i < SIO_BASE)                   region_o = RGN_GPR;
    else if (addr_i < XIO_BASE)              region_o = RGN_SIO;
    else if (!compat_i && addr_i < SRAM_N)   region_o = RGN_XIO;
    else if (addr_i < ext_base)              region_o = RGN_SRAM;
    else if (ext_en_i)                       region_o = RGN_EXT;
    else                                     region_o = RGN_NONE;
  end

  // R2: compatibility layout has no extended I/O window
  always_comb begin
    if (compat_i === 1'b1)
      assert_compat_no_xio_R2: assert (region_o != RGN_XIO);
  end
endmodule

// File: rtl/dsd_ext_timer.sv
module dsd_ext_timer #(
  parameter int WS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_rd_i,
  input  logic [WS_W-1:0] ws_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            stb_rd_o,
  output logic            stb_wr_o
);
  logic            busy_q, rd_q;
  logic [WS_W-1:0] cnt_q;
  logic            go;

  assign go = start_i && !busy_q;

  // first cycle stalls; busy phase runs ws+1 cycles, last one signals done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      rd_q   <= is_rd_i;
      cnt_q  <= ws_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = busy_q && (cnt_q == '0);
  assign stb_rd_o = busy_q ? rd_q  : (go && is_rd_i);
  assign stb_wr_o = busy_q ? !rd_q : (go && !is_rd_i);

  // R6: one strobe for the whole busy phase, direction kept
  assert_one_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ($countones({stb_rd_o, stb_wr_o}) == 1));
  assert_dir_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(stb_rd_o));
  // R7: captured count only ever decreases during an access
  assert_ws_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> cnt_q < $past(cnt_q) || cnt_q == '0);
endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int WS_W       = 2,
  parameter int GPR_CNT    = 32,
  parameter int SIO_CNT    = 64,
  parameter int XIO_CNT    = 160,
  parameter int SRAM_CNT   = 4096,
  parameter int SRAM_CNT_C = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              compat_i,
  input  logic              ext_en_i,
  input  logic [WS_W-1:0]   wait_sel_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [2:0]        region_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o
);
  region_e rgn;
  logic    ext_req, busy, done;

  dsd_region_dec #(
    .ADDR_W(ADDR_W), .GPR_CNT(GPR_CNT), .SIO_CNT(SIO_CNT), .XIO_CNT(XIO_CNT),
    .SRAM_CNT(SRAM_CNT), .SRAM_CNT_C(SRAM_CNT_C)
  ) i_dec (
    .addr_i(addr_i), .compat_i(compat_i), .ext_en_i(ext_en_i), .region_o(rgn)
  );

  assign ext_req = (rd_i || wr_i) && (rgn == RGN_EXT);

  dsd_ext_timer #(.WS_W(WS_W)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ext_req), .is_rd_i(rd_i),
    .ws_i(wait_sel_i), .busy_o(busy), .done_o(done),
    .stb_rd_o(ext_rd_o), .stb_wr_o(ext_wr_o)
  );

  assign region_o = rgn;
  assign ready_o  = busy ? done : !ext_req;
  assign rdata_o  = (rgn == RGN_NONE) ? '0 : rdata_i;

  // R3: strobes stay quiet outside an off-chip access
  assert_int_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && rgn != RGN_EXT && !busy |-> !ext_rd_o && !ext_wr_o && ready_o);
  // R4: unmapped reads yield zero
  assert_unmapped_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rgn == RGN_NONE |-> rdata_o == '0);
  // R5: a stalled strobe cycle is always followed by another strobe cycle
  assert_strobe_through_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rd_o || ext_wr_o) && !ready_o |=> (ext_rd_o || ext_wr_o));
  // R6: never both strobes
  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ext_rd_o, ext_wr_o}));
endmodule

// File: tb/test_dspace_decoder.sv
module test_dspace_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0, compat = 1'b0, ext_en = 1'b1;
  logic [1:0]  ws = '0;
  logic [7:0]  rdi = 8'hA5;
  logic [2:0]  region;
  logic        ext_rd, ext_wr, ready;
  logic [7:0]  rdo;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dspace_decoder i_dspace_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .compat_i(compat), .ext_en_i(ext_en), .wait_sel_i(ws), .rdata_i(rdi),
    .region_o(region), .ext_rd_o(ext_rd), .ext_wr_o(ext_wr), .ready_o(ready),
    .rdata_o(rdo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {compat, ext_en, addr, region}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h0000, 3'd0}, {1'b0, 1'b1, 16'h001F, 3'd0},
    {1'b0, 1'b1, 16'h0020, 3'd1}, {1'b0, 1'b1, 16'h005F, 3'd1},
    {1'b0, 1'b1, 16'h0060, 3'd2}, {1'b0, 1'b1, 16'h00FF, 3'd2},
    {1'b0, 1'b1, 16'h0100, 3'd3}, {1'b0, 1'b1, 16'h10FF, 3'd3},
    {1'b0, 1'b1, 16'h1100, 3'd4}, {1'b0, 1'b1, 16'hFFFF, 3'd4},
    {1'b0, 1'b0, 16'h1100, 3'd5}, {1'b1, 1'b1, 16'h005F, 3'd1},
    {1'b1, 1'b1, 16'h0060, 3'd3}, {1'b1, 1'b1, 16'h00FF, 3'd3},
    {1'b1, 1'b1, 16'h0FFF, 3'd3}, {1'b1, 1'b1, 16'h1000, 3'd4},
    {1'b1, 1'b0, 16'h1000, 3'd5}, {1'b1, 1'b0, 16'h001F, 3'd0}
  };

  // off-chip access; wait_sel is flipped after the first cycle (R7)
  task automatic ext_access(input bit is_rd, input logic [1:0] w);
    int cyc = 0;
    bit done = 0;
    @(negedge clk);
    addr = 16'h2000; ws = w; rd = is_rd; wr = !is_rd;
    while (!done && cyc < 10) begin
      #2;
      cyc++;
      check(ext_rd == is_rd && ext_wr == !is_rd, "R6 strobe", {ext_rd, ext_wr}, {is_rd, !is_rd});
      if (ready) done = 1;
      @(negedge clk);
      ws = ~w;
    end
    check(cyc == int'(w) + 2, "R5/R7 access length", cyc, int'(w) + 2);
    rd = 0; wr = 0;
    #2;
    check(!ext_rd && !ext_wr && ready, "R6 strobes end", {ext_rd, ext_wr, ready}, 3'b001);
  endtask

  initial begin
    #2;
    check(ready && !ext_rd && !ext_wr, "R9 in reset", {ready, ext_rd, ext_wr}, 3'b100);
    #30 rst_ni = 1'b1;
    @(negedge clk); #2;
    check(ready && !ext_rd && !ext_wr, "R9 after reset", {ready, ext_rd, ext_wr}, 3'b100);

    // R1 R2 R4 decode table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      compat = VEC[i][20]; ext_en = VEC[i][19]; addr = VEC[i][18:3];
      #2;
      check(region == VEC[i][2:0], $sformatf("R1/R2/R4 decode %h", addr), region, VEC[i][2:0]);
    end

    // R3 R8 internal reads and writes
    compat = 0; ext_en = 1;
    @(negedge clk); addr = 16'h0400; rd = 1; rdi = 8'h3C; #2;
    check(ready && !ext_rd && !ext_wr, "R3 sram read", {ready, ext_rd, ext_wr}, 3'b100);
    check(rdo == 8'h3C, "R8 read data", rdo, 8'h3C);
    @(negedge clk); rd = 0; wr = 1; addr = 16'h0080; #2;
    check(ready && !ext_rd && !ext_wr, "R3 xio write", {ready, ext_rd, ext_wr}, 3'b100);
    @(negedge clk); wr = 0;

    // R4 unmapped
    ext_en = 0;
    @(negedge clk); addr = 16'h8000; rd = 1; rdi = 8'hFF; #2;
    check(rdo == 8'h00, "R4 unmapped read data", rdo, 0);
    check(ready && !ext_rd && !ext_wr, "R4 unmapped read strobes", {ready, ext_rd, ext_wr}, 3'b100);
    @(negedge clk); rd = 0; wr = 1; #2;
    check(ready && !ext_rd && !ext_wr, "R4 unmapped write strobes", {ready, ext_rd, ext_wr}, 3'b100);
    @(negedge clk); wr = 0; ext_en = 1;

    // R5 R6 R7 off-chip accesses at every wait setting
    for (int w = 0; w < 4; w++) ext_access(1'b1, 2'(w));
    ext_access(1'b0, 2'd0);
    ext_access(1'b0, 2'd3);
    compat = 1;
    ext_access(1'b1, 2'd2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule